// File: doc/BRIEF.md
# ALU and Post-Shifter for a Microcoded Datapath

This block is the arithmetic stage of a microcoded datapath. One operand comes from a holding register and the other from the B bus. Eight control bits from the current microword configure the stage: a two-bit function code, two operand-enable bits, an invert bit for the first operand, a carry-in bit, and two shift enables. The block produces the shifted result that drives the C bus. It also produces raw negative and zero indications taken from the result before shifting. The block is purely combinational: it holds no registers, selects no bus sources and does not latch flags.

Small constants come from the operand controls and need no constant source. Clearing both enables and adding gives 0. Setting the carry as well gives +1. Clearing the first enable and inverting it gives -1. The carry-in takes effect only for addition. When both shift enables are set, the left shift is applied first and the arithmetic right shift is applied to its result.

Top module: `mc_alu_shift`

## Requirements
- R1: `fsel` selects the operation. 2'b00 gives A AND B, 2'b01 gives A OR B, 2'b10 gives NOT B, and 2'b11 gives A + B.
- R2: When `a_en` is 0, operand A is taken as zero. When `b_en` is 0, operand B is taken as zero.
- R3: `a_inv` inverts operand A after gating, so `a_inv`=1 with `a_en`=0 supplies all ones (-1).
- R4: `carry_in` adds 1 to the sum only when `fsel` is 2'b11. For every other code it has no effect on `c_o`, `neg_o` or `zero_o`.
- R5: `shl_en` shifts the ALU result left by 8 bit positions, filling the low 8 bits with zeros.
- R6: `sra_en` shifts the ALU result right by 1 bit and copies the previous bit 31 into bit 31.
- R7: With both shift enables set, `c_o` equals the arithmetic right shift by 1 of the ALU result after it has been shifted left by 8.
- R8: `neg_o` equals bit 31 of the unshifted ALU result.
- R9: `zero_o` is 1 exactly when the unshifted 32-bit ALU result is zero.
- R10: The carry out of bit 31 is discarded, so 32'hFFFF_FFFF + 1 yields 0 with `zero_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand from the holding register |
| b_i | input | 32 | Operand from the B bus |
| fsel | input | 2 | Function code (AND, OR, NOT B, ADD) |
| a_en | input | 1 | Pass A when 1; zero A when 0 |
| b_en | input | 1 | Pass B when 1; zero B when 0 |
| a_inv | input | 1 | Invert gated A |
| carry_in | input | 1 | Add one extra unit for the ADD code |
| shl_en | input | 1 | Logical left shift by 8 |
| sra_en | input | 1 | Arithmetic right shift by 1 |
| c_o | output | 32 | Shifted result to the C bus |
| neg_o | output | 1 | Sign bit of the unshifted result |
| zero_o | output | 1 | Unshifted result equals zero |

## Verification
The block holds no state, so any fault in gating, function decode or shift ordering appears on `c_o` or the flags for the same input vector, within one sample. The bench covers all 256 control combinations across operand pairs chosen to expose wrong fill bits, a carry leaking into non-add functions, a swapped shift order, and flags taken after the shift instead of before it. Directed vectors check the constants made by gating and the discarded carry at the top bit.

// File: rtl/mc_alu_pkg.sv
package mc_alu_pkg;
   typedef enum logic [1:0] {
      FN_AND  = 2'b00,
      FN_OR   = 2'b01,
      FN_NOTB = 2'b10,
      FN_ADD  = 2'b11
   } fn_e;

   localparam int ADDER_BEHAV  = 0;
   localparam int ADDER_RIPPLE = 1;
endpackage

// File: rtl/mc_operand_gate.sv
module mc_operand_gate #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_raw,
   input  logic [W-1:0] b_raw,
   input  logic         a_en,
   input  logic         b_en,
   input  logic         a_inv,
   output logic [W-1:0] a_g,
   output logic [W-1:0] b_g
);
   always_comb begin
      a_g = a_en ? a_raw : '0;
      if (a_inv) a_g = ~a_g;
      b_g = b_en ? b_raw : '0;
      // R2 and R3 checks on the gated operands
      if (!b_en) assert_b_gated_R2: assert (b_g == '0);
      if (!a_en && a_inv) assert_minus_one_R3: assert (&a_g);
      if (!a_en && !a_inv) assert_a_gated_R2: assert (a_g == '0);
   end
endmodule

// File: rtl/mc_alu_core.sv
module mc_alu_core
   import mc_alu_pkg::*;
#(
   parameter int W          = 32,
   parameter int ADDER_KIND = ADDER_BEHAV
) (
   input  logic [W-1:0] a_g,
   input  logic [W-1:0] b_g,
   input  logic [1:0]   fsel,
   input  logic         carry_in,
   output logic [W-1:0] res
);
   fn_e          fn;
   logic         cin_eff;
   logic [W-1:0] sum;

   assign fn      = fn_e'(fsel);
   assign cin_eff = (fn == FN_ADD) && carry_in;

   generate
      if (ADDER_KIND == ADDER_RIPPLE) begin : g_ripple
         logic [W-1:0] cy;
         assign cy[0] = cin_eff;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i] = a_g[i] ^ b_g[i] ^ cy[i];
            if (i < W-1) begin : g_carry
               assign cy[i+1] = (a_g[i] & b_g[i]) | (cy[i] & (a_g[i] ^ b_g[i]));
            end
         end
      end else if (ADDER_KIND == ADDER_BEHAV) begin : g_behav
         assign sum = a_g + b_g + {{(W-1){1'b0}}, cin_eff};
      end else begin : g_bad_kind
         $error("mc_alu_core: unknown ADDER_KIND");
      end
   endgenerate

   always_comb begin
      unique case (fn)
         FN_AND:  res = a_g & b_g;
         FN_OR:   res = a_g | b_g;
         FN_NOTB: res = ~b_g;
         default: res = sum;
      endcase
      // R1: the logic codes stay within the bounds set by their operands
      if (fn == FN_AND) assert_and_subset_R1: assert ((res & ~a_g) == '0);
      if (fn == FN_OR)  assert_or_cover_R1: assert ((res & a_g) == a_g);
   end
endmodule

// File: rtl/mc_shifter.sv
module mc_shifter #(
   parameter int W      = 32,
   parameter int LSHIFT = 8
) (
   input  logic [W-1:0] din,
   input  logic         shl_en,
   input  logic         sra_en,
   output logic [W-1:0] dout
);
   generate
      if (LSHIFT < 1 || LSHIFT > W-2) begin : g_bad_shift
         $error("mc_shifter: LSHIFT out of range");
      end
   endgenerate

   logic [W-1:0] stage_l;

   always_comb begin
      stage_l = shl_en ? {din[W-1-LSHIFT:0], {LSHIFT{1'b0}}} : din;
      dout    = sra_en ? {stage_l[W-1], stage_l[W-1:1]} : stage_l;
      if (shl_en && !sra_en) assert_zero_fill_R5: assert (dout[LSHIFT-1:0] == '0);
      if (sra_en && !shl_en) assert_sign_kept_R6: assert (dout[W-1] == din[W-1]);
      if (shl_en && sra_en)  assert_order_R7: assert (dout[W-1] == din[W-1-LSHIFT]);
   end
endmodule

// File: rtl/mc_alu_shift.sv
module mc_alu_shift
   import mc_alu_pkg::*;
#(
   parameter int W          = 32,
   parameter int LSHIFT     = 8,
   parameter int ADDER_KIND = ADDER_RIPPLE
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [1:0]   fsel,
   input  logic         a_en,
   input  logic         b_en,
   input  logic         a_inv,
   input  logic         carry_in,
   input  logic         shl_en,
   input  logic         sra_en,
   output logic [W-1:0] c_o,
   output logic         neg_o,
   output logic         zero_o
);
   localparam int MSB = W - 1;

   generate
      if (W < LSHIFT + 2) begin : g_bad_width
         $error("mc_alu_shift: W too small for LSHIFT");
      end
   endgenerate

   logic [W-1:0] a_g;
   logic [W-1:0] b_g;
   logic [W-1:0] alu_res;

   mc_operand_gate #(.W(W)) i_gate (
      .a_raw(a_i), .b_raw(b_i), .a_en(a_en), .b_en(b_en), .a_inv(a_inv),
      .a_g(a_g), .b_g(b_g)
   );

   mc_alu_core #(.W(W), .ADDER_KIND(ADDER_KIND)) i_core (
      .a_g(a_g), .b_g(b_g), .fsel(fsel), .carry_in(carry_in), .res(alu_res)
   );

   mc_shifter #(.W(W), .LSHIFT(LSHIFT)) i_shift (
      .din(alu_res), .shl_en(shl_en), .sra_en(sra_en), .dout(c_o)
   );

   always_comb begin
      neg_o  = alu_res[MSB];
      zero_o = (alu_res == '0);
      // R8/R9 flags come from the unshifted result, not the shifted one
      if (!shl_en && !sra_en) assert_flags_match_out_R9: assert (zero_o == (c_o == '0));
      if (!shl_en && !sra_en) assert_neg_match_out_R8: assert (neg_o == c_o[MSB]);
      if (zero_o) assert_zero_not_neg_R8: assert (!neg_o);
   end
endmodule

// File: tb/test_mc_alu_shift.sv
`timescale 1ns/1ps
module test_mc_alu_shift;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] a_i = '0, b_i = '0;
   logic [1:0]  fsel = '0;
   logic        a_en = 0, b_en = 0, a_inv = 0, carry_in = 0, shl_en = 0, sra_en = 0;
   logic [31:0] c_o;
   logic        neg_o, zero_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   typedef struct {
      logic [31:0] c;
      logic        n;
      logic        z;
      string       tag;
   } exp_t;
   exp_t sb[$];

   mc_alu_shift i_mc_alu_shift (
      .a_i(a_i), .b_i(b_i), .fsel(fsel), .a_en(a_en), .b_en(b_en),
      .a_inv(a_inv), .carry_in(carry_in), .shl_en(shl_en), .sra_en(sra_en),
      .c_o(c_o), .neg_o(neg_o), .zero_o(zero_o)
   );

   always #10 clk = ~clk;

   function automatic string tag_of(bit shl, bit sra, bit [1:0] f, bit inc,
                                    bit ena, bit enb, bit inv);
      if (shl && sra) return "R7";
      if (shl)        return "R5";
      if (sra)        return "R6";
      if (f == 2'b11 && inc) return "R4";
      if (inv)        return "R3";
      if (!ena || !enb) return "R2";
      return "R1";
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(bit [1:0] f, bit ena, bit enb, bit inv, bit inc,
                        bit shl, bit sra, logic [31:0] a, logic [31:0] b, string tag);
      logic [31:0] ea, eb, r, s;
      exp_t e;
      ea = ena ? a : 32'd0;
      if (inv) ea = ~ea;
      eb = enb ? b : 32'd0;
      case (f)
         2'b00: r = ea & eb;
         2'b01: r = ea | eb;
         2'b10: r = ~eb;
         default: r = ea + eb + (inc ? 32'd1 : 32'd0);
      endcase
      s = r;
      if (shl) s = s << 8;
      if (sra) s = $signed(s) >>> 1;
      e.c = s; e.n = r[31]; e.z = (r == 0);
      e.tag = (tag == "") ? tag_of(shl, sra, f, inc, ena, enb, inv) : tag;
      @(posedge clk);
      fsel = f; a_en = ena; b_en = enb; a_inv = inv; carry_in = inc;
      shl_en = shl; sra_en = sra; a_i = a; b_i = b;
      sb.push_back(e);
   endtask

   // monitor: compare at the falling edge, half a period after the drive
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.tag, c_o, e.c);
         check("R8", {31'd0, neg_o}, {31'd0, e.n});
         check("R9", {31'd0, zero_o}, {31'd0, e.z});
      end
   end

   initial begin
      #(20.0 * 200000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] pa [6];
      logic [31:0] pb [6];
      pa = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'h00FF_00FF, 32'h7FFF_FFFF};
      pb = '{32'h0000_0000, 32'h0000_0001, 32'h8000_0001, 32'hA5A5_5A5A, 32'hFFFF_FFFF, 32'h0080_0000};
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: all controls low gives AND of zeros
      check("R2", c_o, 32'd0);
      check("R9", {31'd0, zero_o}, 32'd1);
      rst = 1'b0;

      // directed corner cases
      drive(2'b11, 0, 0, 1, 1, 0, 0, 32'h5555_5555, 32'h1111_1111, "R3"); // -1+0+1 = 0
      drive(2'b11, 0, 0, 0, 1, 0, 0, 32'h5555_5555, 32'h1111_1111, "R4"); // +1
      drive(2'b01, 0, 0, 1, 0, 0, 0, 32'h5555_5555, 32'h0, "R3");         // -1
      drive(2'b01, 1, 1, 0, 1, 0, 0, 32'h0000_00F0, 32'h0000_000F, "R4"); // carry ignored
      drive(2'b11, 1, 1, 0, 1, 0, 0, 32'hFFFF_FFFF, 32'h0, "R10");
      drive(2'b11, 1, 1, 0, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, "R10");
      drive(2'b10, 1, 1, 0, 0, 0, 1, 32'h0, 32'h7FFF_FFFF, "R6");          // 8000_0000 >>> 1
      drive(2'b01, 1, 0, 0, 0, 1, 1, 32'h0080_0000, 32'h0, "R7");
      drive(2'b01, 1, 0, 0, 0, 1, 0, 32'h00FF_FFFF, 32'h0, "R5");

      // all 256 control words over several operand pairs
      for (int p = 0; p < 6; p++) begin
         for (int c = 0; c < 256; c++) begin
            drive(c[1:0], c[2], c[3], c[4], c[5], c[6], c[7], pa[p], pb[p], "");
         end
      end

      while (sb.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule